// File: doc/BRIEF.md
# Triggered Compare-and-Clear Unit

This block sits beside a pulse counter and decides when that counter should be cleared. It compares the live count with a TOP value on every cycle. When a trigger event arrives and the compare holds in that cycle, it issues a one-cycle clear pulse that the counter uses to return to its start value. The counter itself lives outside this block.

A trigger event comes from one of two sources. In periodic mode it is a sample-clock tick, thinned by a prescaler that passes every 1st, 2nd, 4th or 8th tick. In edge mode it is a chosen edge of an asynchronous trigger input, which is first passed through a two-flop synchronizer. The same synchronized trigger level can also hold off the counter through a count-enable gate. One polarity bit sets both which edge triggers and which level blocks counting.

The compare has three forms: count at or below TOP, count at or above TOP, and a window. In window form the upper half of TOP is the ceiling and the lower half is the floor.

Top module: `trig_cmp_clear`

## Requirements
- R1: When every configuration input is zero (mode off, divide by 1, at-or-below compare, polarity 0, gating off) and reset has just been released, clear_o is 0 and cnt_en_o is 1.
- R2: match_o follows count_i, top_i and cfg_cmp in the same cycle, with no register in the path. Code 0 matches when count_i <= top_i, code 1 matches when count_i >= top_i, and code 3 never matches. The compare is unsigned.
- R3: With cfg_cmp = 2, match_o is 1 exactly when count_i <= top_i[15:8] and count_i >= top_i[7:0]. Both bounds are zero-extended. If the ceiling is below the floor, there is never a match.
- R4: cfg_mode codes are 0 off, 1 periodic, 2 edge and 3 off. In either off code, neither ticks nor trigger edges produce a clear.
- R5: In periodic mode with cfg_div = d, every 2^d-th tick since the prescaler last restarted is a trigger event. Any cycle with tick_i = 0 is never a trigger event.
- R6: The prescaler count restarts whenever cfg_mode changes. Outside periodic mode, tick_i and cfg_div have no effect on clear_o.
- R7: In edge mode, trig_i passes through two synchronizing flops. With cfg_pol = 0 a rising edge is the trigger, and with cfg_pol = 1 a falling edge is. The pulse on clear_o appears in the cycle after the third rising clock edge that samples the new trig_i level. The other edge direction produces no clear.
- R8: clear_o is 1 for exactly the one cycle after a clock edge at which a trigger event and match_o = 1 coincide. In every other cycle it is 0.
- R9: With cfg_gate_en = 1, cnt_en_o is 0 while the synchronized trigger level is high (cfg_pol = 0) or low (cfg_pol = 1), and 1 otherwise. A change on trig_i reaches cnt_en_o after two clock edges. With cfg_gate_en = 0, cnt_en_o is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | Trigger mode: 0 off, 1 periodic, 2 edge, 3 off |
| cfg_div | input | DIV_W | Prescaler select; periodic mode triggers every 2^cfg_div ticks |
| cfg_cmp | input | 2 | Compare form: 0 at-or-below, 1 at-or-above, 2 window, 3 none |
| cfg_pol | input | 1 | 0: rising edge triggers, high blocks; 1: falling edge triggers, low blocks |
| cfg_gate_en | input | 1 | Enables gating of the count enable by the trigger level |
| count_i | input | CNT_W | Current counter value |
| top_i | input | CNT_W | TOP value; in window form, its halves are ceiling and floor |
| tick_i | input | 1 | Sample-clock tick, one cycle wide |
| trig_i | input | 1 | Asynchronous trigger input |
| clear_o | output | 1 | One-cycle clear request to the counter |
| cnt_en_o | output | 1 | Count enable after gating |
| match_o | output | 1 | Current compare result |

## Verification
The bench builds the block with its default parameters: CNT_W = 16, DIV_W = 2 and two synchronizer stages. This gives the byte-split window compare its real geometry and makes all four prescaler ratios reachable. With small count values and a handful of TOP values, including an inverted window, the compare is swept over all four codes and every bound relation. Every prescaler ratio is run with both dense and sparse tick patterns. Every combination of polarity, edge direction and gate level is also walked through.

// File: rtl/trig_cmp_clear_pkg.sv
package trig_cmp_clear_pkg;

    typedef enum logic [1:0] {
        TM_OFF   = 2'd0,
        TM_TICK  = 2'd1,
        TM_EDGE  = 2'd2,
        TM_IDLE  = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        CM_LE    = 2'd0,
        CM_GE    = 2'd1,
        CM_WIN   = 2'd2,
        CM_NONE  = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       clear;
    } tcc_ctl_t;

endpackage

// File: rtl/tcc_trig_sync.sv
module tcc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pol,
    input  logic async_i,
    output logic level_o,
    output logic edge_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;
    logic               prev;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], async_i};
        level_o = chain_q[STAGES-1];
        prev    = chain_q[STAGES];
        edge_o  = pol ? (prev & ~level_o) : (level_o & ~prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

endmodule

// File: rtl/tcc_prescaler.sv
module tcc_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_sel,
    output logic             fire_o
);
    localparam int MAX_EXP = (1 << DIV_W) - 1;
    localparam int PW      = (MAX_EXP < 1) ? 1 : MAX_EXP;

    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit  = PW'((32'd1 << div_sel) - 32'd1);
        fire_o = run_i & ~restart_i & tick_i & (cnt_q >= limit);
        cnt_d  = cnt_q;
        if (restart_i || !run_i) cnt_d = '0;
        else if (tick_i)         cnt_d = fire_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tcc_compare.sv
module tcc_compare import trig_cmp_clear_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic [1:0]       cmp_sel,
    output logic             match_o
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] ceil_v, floor_v;

    always_comb begin
        ceil_v  = {{(CNT_W-HALF){1'b0}}, top_i[CNT_W-1:CNT_W-HALF]};
        floor_v = {{(CNT_W-HALF){1'b0}}, top_i[HALF-1:0]};
        case (cmp_mode_e'(cmp_sel))
            CM_LE:   match_o = (count_i <= top_i);
            CM_GE:   match_o = (count_i >= top_i);
            CM_WIN:  match_o = (count_i <= ceil_v) && (count_i >= floor_v);
            default: match_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/trig_cmp_clear.sv
module trig_cmp_clear import trig_cmp_clear_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       cfg_cmp,
    input  logic             cfg_pol,
    input  logic             cfg_gate_en,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             tick_i,
    input  logic             trig_i,
    output logic             clear_o,
    output logic             cnt_en_o,
    output logic             match_o
);
    tcc_ctl_t st_d, st_q;
    logic     trig_lvl, trig_edge, tick_fire, mode_chg, run_tick, evt;

    tcc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pol     (cfg_pol),
        .async_i (trig_i),
        .level_o (trig_lvl),
        .edge_o  (trig_edge)
    );

    tcc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_tick),
        .restart_i (mode_chg),
        .tick_i    (tick_i),
        .div_sel   (cfg_div),
        .fire_o    (tick_fire)
    );

    tcc_compare #(.CNT_W(CNT_W)) u_cmp (
        .count_i (count_i),
        .top_i   (top_i),
        .cmp_sel (cfg_cmp),
        .match_o (match_o)
    );

    always_comb begin
        mode_chg = (cfg_mode != st_q.mode);
        run_tick = (trig_mode_e'(cfg_mode) == TM_TICK);
        case (trig_mode_e'(cfg_mode))
            TM_TICK: evt = tick_fire;
            TM_EDGE: evt = trig_edge;
            default: evt = 1'b0;
        endcase
        st_d.mode  = cfg_mode;
        st_d.clear = evt & match_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clear_o  = st_q.clear;
    assign cnt_en_o = ~(cfg_gate_en & (trig_lvl ^ cfg_pol));

endmodule

// File: rtl/trig_cmp_clear_chk.sv
module trig_cmp_clear_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg_mode,
    input logic [1:0]       cfg_cmp,
    input logic             cfg_gate_en,
    input logic [CNT_W-1:0] top_i,
    input logic             tick_i,
    input logic             clear_o,
    input logic             cnt_en_o,
    input logic             match_o
);
    localparam int HALF = CNT_W / 2;

    // R4
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mode) == 2'd0 || $past(cfg_mode) == 2'd3) |-> !clear_o);

    // R8
    clear_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |-> $past(match_o));

    // R5
    tick_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mode) == 2'd1 && !$past(tick_i)) |-> !clear_o);

    // R9
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_gate_en |-> cnt_en_o);

    // R3
    inverted_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cmp == 2'd2 && top_i[CNT_W-1:CNT_W-HALF] < top_i[HALF-1:0]) |-> !match_o);

    // R2
    none_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cmp == 2'd3) |-> !match_o);

endmodule

bind trig_cmp_clear trig_cmp_clear_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .cfg_cmp     (cfg_cmp),
    .cfg_gate_en (cfg_gate_en),
    .top_i       (top_i),
    .tick_i      (tick_i),
    .clear_o     (clear_o),
    .cnt_en_o    (cnt_en_o),
    .match_o     (match_o)
);

// File: tb/test_trig_cmp_clear.sv
`timescale 1ns/1ps
module test_trig_cmp_clear;
    localparam int CNT_W = 16;
    localparam int DIV_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cfg_mode = '0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [1:0]       cfg_cmp = '0;
    logic             cfg_pol = 1'b0;
    logic             cfg_gate_en = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic [CNT_W-1:0] top_i = '0;
    logic             tick_i = 1'b0;
    logic             trig_i = 1'b0;
    logic             clear_o, cnt_en_o, match_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    trig_cmp_clear #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_trig_cmp_clear (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_div(cfg_div),
        .cfg_cmp(cfg_cmp), .cfg_pol(cfg_pol), .cfg_gate_en(cfg_gate_en),
        .count_i(count_i), .top_i(top_i), .tick_i(tick_i), .trig_i(trig_i),
        .clear_o(clear_o), .cnt_en_o(cnt_en_o), .match_o(match_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_match(int cmp, int c, int t);
        case (cmp)
            0: return int'(c <= t);
            1: return int'(c >= t);
            2: return int'(c <= (t >> 8) && c >= (t & 255));
            default: return 0;
        endcase
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Periodic run: tick every cycle, or every other cycle when sparse
    task automatic periodic_run(int div, bit sparse, int cnt, int top, string req);
        int  tk = 0;
        int  expn = 0;
        cfg_mode = 2'd0; tick_i = 1'b0; idle(2);
        cfg_div = DIV_W'(div); cfg_cmp = 2'd0;
        count_i = CNT_W'(cnt); top_i = CNT_W'(top);
        cfg_mode = 2'd1; idle(3);
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            if (j > 0) chk(req, int'(clear_o), expn);
            tick_i = sparse ? (j % 2 == 0) : 1'b1;
            if (tick_i) begin
                tk++;
                expn = ((tk % (1 << div)) == 0) ? ref_match(0, cnt, top) : 0;
            end else expn = 0;
        end
        @(negedge clk); chk(req, int'(clear_o), expn);
        tick_i = 1'b0;
        @(negedge clk); chk(req, int'(clear_o), 0);
    endtask

    // Edge mode: one transition of trig_i, watch the pulse window
    task automatic edge_run(bit pol, bit rising, int cnt, int top, string req);
        int fire;
        cfg_mode = 2'd2; cfg_pol = pol; cfg_cmp = 2'd0; cfg_gate_en = 1'b0;
        cfg_div = 2'd3; tick_i = 1'b1;
        count_i = CNT_W'(cnt); top_i = CNT_W'(top);
        trig_i = ~rising; idle(6);
        fire = (rising ^ pol) ? ref_match(0, cnt, top) : 0;
        trig_i = rising;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk(req, int'(clear_o), (k == 3) ? fire : 0);
        end
        tick_i = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        count_i = 16'd5; top_i = 16'd7;
        @(negedge clk);
        // R1 reset state with all-zero configuration
        chk("R1 clear", int'(clear_o), 0);
        chk("R1 cnt_en", int'(cnt_en_o), 1);
        chk("R1 match", int'(match_o), 1);
        // R4 mode off: ticks and toggles give nothing
        for (int m = 0; m < 4; m += 3) begin
            cfg_mode = 2'(m);
            for (int j = 0; j < 8; j++) begin
                tick_i = 1'b1; trig_i = j[1];
                @(negedge clk);
                chk("R4 off mode", int'(clear_o), 0);
            end
        end
        tick_i = 1'b0; trig_i = 1'b0; cfg_mode = 2'd0; idle(4);

        // R2 / R3 compare sweep
        begin
            int tops[6] = '{0, 16'h0014, 16'h2010, 16'h1020, 16'hFFFF, 16'h1414};
            for (int cm = 0; cm < 4; cm++)
                for (int ti = 0; ti < 6; ti++)
                    for (int c = 0; c <= 40; c++) begin
                        cfg_cmp = 2'(cm); top_i = CNT_W'(tops[ti]); count_i = CNT_W'(c);
                        #0.5;
                        chk(cm == 2 ? "R3 window" : "R2 compare", int'(match_o), ref_match(cm, c, tops[ti]));
                    end
            cfg_cmp = 2'd1; top_i = 16'h8000; count_i = 16'hFFFF; #0.5;
            chk("R2 unsigned", int'(match_o), 1);
        end

        // R5 prescaler ratios, dense and sparse ticks
        for (int d = 0; d < 4; d++) begin
            periodic_run(d, 1'b0, 0, 16'hFFFF, "R5 dense");
            periodic_run(d, 1'b1, 3, 16'h0010, "R5 sparse");
        end
        // R8 no match: trigger fires but no clear
        periodic_run(0, 1'b0, 9, 3, "R8 periodic no match");

        // R6 prescaler restart on mode change
        cfg_mode = 2'd0; idle(2);
        cfg_div = 2'd2; count_i = '0; top_i = 16'hFFFF; cfg_cmp = 2'd0;
        cfg_mode = 2'd1; idle(3);
        for (int j = 0; j < 2; j++) begin
            tick_i = 1'b1; @(negedge clk); chk("R6 pre", int'(clear_o), 0);
        end
        tick_i = 1'b0;
        cfg_mode = 2'd2; @(negedge clk);
        cfg_mode = 2'd1; idle(2);
        for (int j = 1; j <= 5; j++) begin
            tick_i = 1'b1; @(negedge clk);
            chk("R6 restart", int'(clear_o), (j == 4) ? 1 : 0);
        end
        tick_i = 1'b0; idle(2);

        // R7 edge polarity and latency (ticks held high: R6 no effect)
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 2; r++)
                edge_run(p[0], r[0], 0, 16'hFFFF, "R7 edge");
        // R8 edge without match
        edge_run(1'b0, 1'b1, 5, 2, "R8 edge no match");

        // R9 gating
        cfg_mode = 2'd0;
        for (int g = 0; g < 2; g++)
            for (int p = 0; p < 2; p++)
                for (int l = 0; l < 2; l++) begin
                    cfg_gate_en = g[0]; cfg_pol = p[0];
                    trig_i = ~l[0]; idle(4);
                    trig_i = l[0];
                    @(negedge clk);
                    chk("R9 gate hold", int'(cnt_en_o), g ? int'(!((~l[0]) ^ p[0])) : 1);
                    @(negedge clk);
                    chk("R9 gate level", int'(cnt_en_o), g ? int'(!(l[0] ^ p[0])) : 1);
                end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule